// File: doc/BRIEF.md
# Partitioned Clock-Gated State Machine Controller

This block is one finite-state machine split into four sub-machines, of which only one is active at any time. A two-bit partition pointer names the active sub-machine. A single three-bit local register, shared by all four sub-machines, holds the position inside it. Each sub-machine's next-state logic is enabled only while its partition is active. Idle partitions have their inputs forced to zero, so their logic does not toggle and they can drive no update. The per-partition enables are brought out so that the surrounding design can gate clocks or hold operands of the logic tied to each partition.

The sub-machines hold 2, 4, 4 and 8 local states. Local code 0 in every partition is the coupled entry state. When a sub-machine leaves for another partition, it writes code 0, and the pointer moves to the target partition on the same edge. The entry state is therefore shared by the leaving exit state and the arriving partition. On the next edge the entry state moves on to code 1 without looking at the command, so a crossing costs two cycles where an unpartitioned machine would need one. A registered Moore output gives a flat state number built from the pointer and the local code.

Top module: `pfsm_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the machine goes to partition 0, local code 0. After that edge, `state_id_o` is 0 and `part_en_o` is 4'b0001.
- R2: In local code 0 (the entry state), the next edge moves to code 1 of the same partition whatever `cmd_i` holds.
- R3: Command 2'b00 (hold) in a non-entry state leaves partition and local code unchanged.
- R4: Command 2'b01 (step) in a non-entry state advances the local code by one. From the partition's last code (state count minus 1), it wraps to code 1. In partition 0 (2 states) a step therefore keeps code 1.
- R5: Command 2'b10 (forward) in a non-entry state moves on one edge to partition p+1 (partition 3 goes to 0) at local code 0. The next edge reaches code 1, so the target is reached two cycles after the command.
- R6: Command 2'b11 (home) in a non-entry state moves to partition 0, local code 0, from any partition, including partition 0 itself.
- R7: In every cycle after reset, exactly one bit of `part_en_o` is high. Bit p is high exactly when partition p is active.
- R8: `state_id_o` equals base(p) + local code, with bases 0, 2, 6 and 10 for partitions 0 to 3. The local code never exceeds the active partition's last code, so `state_id_o` stays below 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 2 | Command: 00 hold, 01 step, 10 forward, 11 home |
| state_id_o | output | 5 | Registered flat state number (Moore output) |
| part_en_o | output | 4 | One-hot activity enable per partition |

## Verification
The case that is hardest to reach from the ports is the handover cycle. Right after a crossing the machine sits in a coupled entry state and must discard whatever command arrives, including a second crossing or a home request. A directed vector table places forward and home commands exactly in those cycles. It also walks the eight-state partition through its full wrap and crosses from partition 3 back to 0. A long pseudo-random command stream is then checked against an unpartitioned reference model in the bench. That model delays by one cycle every transition that crosses partitions, which exercises back-to-back crossings and homes arriving in the handover cycle far more often than a hand-written sequence could.

// File: rtl/pfsm_pkg.sv
// Shared types for the partitioned state machine controller.
// Assumes a 2-bit command input; the encoding is fixed here.
package pfsm_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'b00,
        CMD_STEP = 2'b01,
        CMD_FWD  = 2'b10,
        CMD_HOME = 2'b11
    } pfsm_cmd_e;

endpackage

// File: rtl/pfsm_part.sv
// Next-state logic of one sub-machine with NSTATES local states.
// Code 0 is the coupled entry state and is left unconditionally for code 1.
// Assumes cur_i already lies in 0..NSTATES-1 while en_i is high. With en_i low,
// all inputs are masked and every output is zero, so this partition adds
// nothing to the shared OR-combined next state.
module pfsm_part
    import pfsm_pkg::*;
#(
    parameter int NSTATES = 4,
    parameter int LW      = 3
) (
    input  logic          en_i,
    input  logic [1:0]    cmd_i,
    input  logic [LW-1:0] cur_i,
    output logic [LW-1:0] nxt_o,
    output logic          fwd_o,
    output logic          home_o
);

    localparam logic [LW-1:0] LAST  = LW'(NSTATES - 1);
    localparam logic [LW-1:0] FIRST = LW'(1);

    pfsm_cmd_e     cmd_m;
    logic [LW-1:0] cur_m;

    // Input disabling: an idle partition sees all-zero operands.
    always_comb begin
        cmd_m = en_i ? pfsm_cmd_e'(cmd_i) : CMD_HOLD;
        cur_m = en_i ? cur_i : '0;
    end

    // Local transition function of this partition.
    always_comb begin
        nxt_o  = '0;
        fwd_o  = 1'b0;
        home_o = 1'b0;
        if (en_i) begin
            if (cur_m == '0) begin
                nxt_o = FIRST;
            end else begin
                unique case (cmd_m)
                    CMD_HOLD: nxt_o = cur_m;
                    CMD_STEP: nxt_o = (cur_m == LAST) ? FIRST : cur_m + LW'(1);
                    CMD_FWD:  fwd_o = 1'b1;
                    CMD_HOME: home_o = 1'b1;
                    default:  nxt_o = cur_m;
                endcase
            end
        end
    end

endmodule

// File: rtl/pfsm_global.sv
// Global-state pointer: names the single active partition.
// Assumes fwd_i and home_i come from the active partition only, so they are
// never both high. The pointer changes on the same edge as the local register
// enters the coupled entry code. The enables are a plain decode of the pointer.
module pfsm_global #(
    parameter int NPART = 4,
    parameter int GW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_i,
    input  logic             home_i,
    output logic [GW-1:0]    g_q,
    output logic [GW-1:0]    g_nxt,
    output logic [NPART-1:0] en_o
);

    localparam logic [GW-1:0] G_LAST = GW'(NPART - 1);

    // Pointer next value: home wins, then forward with wrap, else keep.
    always_comb begin
        if (home_i)
            g_nxt = '0;
        else if (fwd_i)
            g_nxt = (g_q == G_LAST) ? '0 : g_q + GW'(1);
        else
            g_nxt = g_q;
    end

    // Pointer register, partition 0 after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            g_q <= '0;
        else
            g_q <= g_nxt;
    end

    // One enable per partition, decoded from the pointer.
    for (genvar p = 0; p < NPART; p++) begin : g_dec
        assign en_o[p] = (g_q == GW'(p));
    end

endmodule

// File: rtl/pfsm_ctrl.sv
// Partitioned state machine controller, top level.
// One shared local register (wide enough for the largest partition) plus a
// partition pointer. Only the active partition's next-state logic is enabled;
// the partition outputs are OR-combined, which relies on at most one enable.
// state_id_o is a registered Moore output: base of partition + local code.
module pfsm_ctrl #(
    parameter int NPART         = 4,
    parameter int PART_N [NPART] = '{2, 4, 4, 8}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cmd_i,
    output logic [4:0]  state_id_o,
    output logic [3:0]  part_en_o
);

    // Sum of the state counts of partitions below index upto.
    function automatic int sum_below(input int upto);
        int s;
        s = 0;
        for (int i = 0; i < upto; i++) s += PART_N[i];
        return s;
    endfunction

    // Widest local code needed by any partition.
    function automatic int max_width(input int cnt);
        int w;
        w = 1;
        for (int i = 0; i < cnt; i++)
            if ($clog2(PART_N[i]) > w) w = $clog2(PART_N[i]);
        return w;
    endfunction

    localparam int GW    = (NPART > 1) ? $clog2(NPART) : 1;
    localparam int LW    = max_width(NPART);
    localparam int TOTAL = sum_below(NPART);
    localparam int IDW   = $clog2(TOTAL);

    logic [GW-1:0]    g_q;
    logic [GW-1:0]    g_nxt;
    logic [NPART-1:0] en;
    logic [LW-1:0]    l_q;
    logic [LW-1:0]    l_nxt;
    logic             fwd_any;
    logic             home_any;
    logic [IDW-1:0]   id_q;

    logic [LW-1:0]    nxt_arr  [NPART];
    logic [NPART-1:0] fwd_arr;
    logic [NPART-1:0] home_arr;
    logic [IDW-1:0]   base_w   [NPART];

    // One next-state block and one base offset per partition.
    for (genvar p = 0; p < NPART; p++) begin : g_part
        pfsm_part #(
            .NSTATES (PART_N[p]),
            .LW      (LW)
        ) u_part (
            .en_i   (en[p]),
            .cmd_i  (cmd_i),
            .cur_i  (l_q),
            .nxt_o  (nxt_arr[p]),
            .fwd_o  (fwd_arr[p]),
            .home_o (home_arr[p])
        );
        assign base_w[p] = IDW'(sum_below(p));
    end

    // Merge the partition results; idle partitions contribute zeros.
    always_comb begin
        l_nxt = '0;
        for (int p = 0; p < NPART; p++) l_nxt |= nxt_arr[p];
        fwd_any  = |fwd_arr;
        home_any = |home_arr;
    end

    pfsm_global #(
        .NPART (NPART),
        .GW    (GW)
    ) u_global (
        .clk    (clk),
        .rst_n  (rst_n),
        .fwd_i  (fwd_any),
        .home_i (home_any),
        .g_q    (g_q),
        .g_nxt  (g_nxt),
        .en_o   (en)
    );

    // Shared local-state register, entry code 0 after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            l_q <= '0;
        else
            l_q <= l_nxt;
    end

    // Registered Moore output from the next (pointer, local) pair.
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_q <= '0;
        else
            id_q <= base_w[g_nxt] + IDW'(l_nxt);
    end

    assign state_id_o = 5'(id_q);
    assign part_en_o  = 4'(en);

endmodule

// File: rtl/pfsm_ctrl_chk.sv
// Assertion checker for pfsm_ctrl, attached by the bind below.
// Watches the pointer, the shared local register, the command and the enables.
module pfsm_ctrl_chk
    import pfsm_pkg::*;
#(
    parameter int NPART          = 4,
    parameter int PART_N [NPART] = '{2, 4, 4, 8},
    parameter int GW             = 2,
    parameter int LW             = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cmd,
    input logic [GW-1:0]    g_q,
    input logic [LW-1:0]    l_q,
    input logic [3:0]       part_en
);

    logic [LW-1:0] last_c;
    logic [GW-1:0] g_succ;

    // Last legal code of the active partition and its successor partition.
    always_comb begin
        last_c = LW'(PART_N[g_q] - 1);
        g_succ = (g_q == GW'(NPART - 1)) ? '0 : g_q + GW'(1);
    end

    a_r7_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(part_en) == 1);

    a_r7_enable_matches: assert property (@(posedge clk) disable iff (!rst_n)
        part_en[g_q] == 1'b1);

    a_r2_entry_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q == '0) |=> (l_q == LW'(1) && $stable(g_q)));

    a_r3_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q != '0 && cmd == CMD_HOLD) |=> ($stable(l_q) && $stable(g_q)));

    a_r4_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q != '0 && l_q == last_c && cmd == CMD_STEP) |=> (l_q == LW'(1) && $stable(g_q)));

    a_r4_step_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q != '0 && l_q != last_c && cmd == CMD_STEP) |=> (l_q == $past(l_q) + LW'(1)));

    a_r5_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q != '0 && cmd == CMD_FWD) |=> (l_q == '0 && g_q == $past(g_succ)));

    a_r6_home: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q != '0 && cmd == CMD_HOME) |=> (l_q == '0 && g_q == '0));

    a_r8_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        l_q <= last_c);

endmodule

bind pfsm_ctrl pfsm_ctrl_chk #(
    .NPART  (NPART),
    .PART_N (PART_N),
    .GW     (GW),
    .LW     (LW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd_i),
    .g_q     (g_q),
    .l_q     (l_q),
    .part_en (part_en_o)
);

// File: tb/tb_pfsm_ctrl.sv
// Self-checking bench for pfsm_ctrl: a vector table, directed corner cases,
// then a pseudo-random stream against an unpartitioned reference model that
// lets each crossing transition take one extra cycle.
module tb_pfsm_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd_i = 2'b00;
    logic [4:0] state_id_o;
    logic [3:0] part_en_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // Reference model: flat state (partition, code) plus a handover flag.
    int  mp = 0;
    int  mc = 1;
    bit  mh = 1'b1;

    // Table entry: {cmd[1:0], expected state_id[4:0]}.
    localparam int NVEC = 24;
    localparam logic [6:0] VEC [NVEC] = '{
        {2'd0, 5'd1},   // R2 entry ignores hold
        {2'd1, 5'd1},   // R4 step in 2-state partition stays
        {2'd0, 5'd1},   // R3 hold
        {2'd2, 5'd2},   // R5 forward to partition 1 entry
        {2'd3, 5'd3},   // R2 home ignored in entry
        {2'd1, 5'd4},   // R4
        {2'd1, 5'd5},   // R4
        {2'd1, 5'd3},   // R4 wrap to code 1
        {2'd2, 5'd6},   // R5 forward to partition 2
        {2'd1, 5'd7},   // R2 step ignored in entry
        {2'd1, 5'd8},   // R4
        {2'd2, 5'd10},  // R5 forward to partition 3
        {2'd0, 5'd11},  // R2
        {2'd1, 5'd12},  // R4
        {2'd2, 5'd0},   // R5 partition 3 wraps to 0
        {2'd0, 5'd1},   // R2
        {2'd3, 5'd0},   // R6 home from partition 0
        {2'd2, 5'd1},   // R2 forward ignored in entry
        {2'd2, 5'd2},   // R5
        {2'd0, 5'd3},   // R2
        {2'd2, 5'd6},   // R5
        {2'd0, 5'd7},   // R2
        {2'd3, 5'd0},   // R6 home from partition 2
        {2'd0, 5'd1}    // R2
    };

    pfsm_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd_i),
        .state_id_o (state_id_o),
        .part_en_o  (part_en_o)
    );

    always #5 clk = ~clk;

    function automatic int nst(input int p);
        return (p == 0) ? 2 : (p == 3) ? 8 : 4;
    endfunction

    function automatic int base_of(input int p);
        return (p == 0) ? 0 : (p == 1) ? 2 : (p == 2) ? 6 : 10;
    endfunction

    function automatic int part_of(input int id);
        return (id < 2) ? 0 : (id < 6) ? 1 : (id < 10) ? 2 : 3;
    endfunction

    function automatic int model_id();
        return base_of(mp) + (mh ? 0 : mc);
    endfunction

    task automatic model_reset();
        mp = 0; mc = 1; mh = 1'b1;
    endtask

    // One edge of the reference: a crossing is held back one cycle.
    task automatic model_apply(input logic [1:0] c);
        if (mh) begin
            mh = 1'b0;
        end else begin
            case (c)
                2'd1: mc = (mc == nst(mp) - 1) ? 1 : mc + 1;
                2'd2: begin mp = (mp + 1) % 4; mc = 1; mh = 1'b1; end
                2'd3: begin mp = 0; mc = 1; mh = 1'b1; end
                default: ;
            endcase
        end
    endtask

    task automatic check(input string req, input int exp_id);
        logic [3:0] exp_en;
        exp_en = 4'b0001 << part_of(exp_id);
        n_tests++;
        if (state_id_o !== 5'(exp_id) || part_en_o !== exp_en) begin
            n_fail++;
            $display("FAIL %s: state_id=%0d part_en=%b, expected state_id=%0d part_en=%b",
                     req, state_id_o, part_en_o, exp_id, exp_en);
        end
    endtask

    task automatic cycle(input logic [1:0] c);
        cmd_i = c;
        @(posedge clk);
        model_apply(c);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (2) @(negedge clk);
        check("R1 reset", 0);
        rst_n = 1'b1;
        model_reset();

        // Vector table walk.
        for (int i = 0; i < NVEC; i++) begin
            cycle(VEC[i][6:5]);
            check($sformatf("R2-R6 vector %0d", i), int'(VEC[i][4:0]));
        end

        // R4: full wrap of the 8-state partition.
        cycle(2'd2); cycle(2'd0); cycle(2'd2); cycle(2'd0); cycle(2'd2); cycle(2'd0);
        check("R5 reach partition 3", 11);
        for (int k = 0; k < 6; k++) cycle(2'd1);
        check("R4 last code of partition 3", 17);
        cycle(2'd1);
        check("R4 wrap in partition 3", 11);

        // R1: synchronous reset in the middle of operation.
        cmd_i = 2'd1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run reset", 0);
        rst_n = 1'b1;
        model_reset();

        // R7, R8: pseudo-random stream against the reference model.
        begin
            logic [15:0] lfsr;
            lfsr = 16'hACE1;
            for (int k = 0; k < 400; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                cycle(lfsr[1:0]);
                check("R8 random vs reference", model_id());
                n_tests++;
                if ($countones(part_en_o) != 1) begin
                    n_fail++;
                    $display("FAIL R7: part_en=%b, expected exactly one bit set", part_en_o);
                end
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule